// File: doc/BRIEF.md
# Keyed Indexed Configuration Port

This block is the configuration front end of a legacy I/O controller. An 8-bit host bus reaches it through two ports: an index port that names a register and a data port that reads or writes the named register. After reset the front end is locked. It opens only when the host writes the two key bytes 0x51 and 0x23 to the index port, one directly after the other. A single command byte, 0xBB, written to the index port closes it again.

While open, the global registers sit below index 0x30: device select, soft reset and the power-down and pin-option controls. From index 0x30 upward, every register belongs to a per-device bank. The device-select register picks which of the logical devices (0 to 8 by default) is visible there. Each bank holds an enable flag, a 16-bit base I/O address, an IRQ number, a DMA channel and a small set of mode registers. The keyboard device also has a second IRQ number for the mouse. Each device's enable flag, base address and IRQ are driven in parallel to the rest of the chip.

Top module: `lockcfg_port`

## Requirements
- R1: After reset the port is locked, and every device enable, base address, IRQ and global control output is zero.
- R2: Index-port writes of 0x51 and then 0x23 with no other index-port write between them open the port. Repeated 0x51 bytes before 0x23 still count as the first key byte. While open, an index-port read returns the last index written.
- R3: While locked, an index-port write of 0x23 that does not directly follow 0x51 leaves the port locked. Any index-port write other than the two key bytes discards a pending first key byte.
- R4: While locked, reads of either port return 0xFF. Data-port writes change no register. Index-port writes leave the stored index unchanged.
- R5: While open, an index-port write of 0xBB locks the port and keeps the stored index.
- R6: Index 0x07 holds the device number (low 4 bits). Bank-register accesses reach only the bank of the selected device, and each bank keeps its own values.
- R7: In each bank, index 0x30 bit 0 is the enable, 0x60/0x61 are the base address high/low bytes, 0x70 is the IRQ, 0x74 is the DMA channel, and 0xF0 to 0xF4 are five separate mode registers. The exported enable, base and IRQ follow these registers.
- R8: Index 0x72 is a second IRQ register that exists only in the keyboard bank (device 7). In any other bank it reads 0x00 and ignores writes.
- R9: Global indices 0x22, 0x23 and 0x24 are 8-bit read/write registers (direct power-down, automatic power-down, pin options) driven to outputs.
- R10: A data write to index 0x02 with bit 0 set returns all configuration registers, including the device select, to zero and leaves the port open. With bit 0 clear it has no effect.
- R11: Unimplemented indices read 0x00 and ignore writes.
- R12: A data-port read in the same cycle as a data-port write returns the value held before that write. The written value is visible from the next cycle.
- R13: A device number of 9 or more selects no bank: bank indices read 0x00 and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Host write strobe, one byte per cycle |
| io_rd | input | 1 | Host read strobe |
| io_dsel | input | 1 | Port select: 0 index port, 1 data port |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data (combinational, 0x00 when io_rd is low) |
| dev_act | output | NDEV | Per-device enable flags |
| dev_base | output | NDEV*16 | Per-device base I/O address, device i at bits [16i+15:16i] |
| dev_irq | output | NDEV*IRQW | Per-device IRQ number, device i at bits [IRQW*i+IRQW-1:IRQW*i] |
| pd_direct | output | 8 | Direct power-down control |
| pd_auto | output | 8 | Automatic power-down control |
| pin_opt | output | 8 | Pin polarity and mode options |

## Verification
Two functions meet in one cycle: a read of a register and a write that replaces it. The bench raises both strobes on the data port in the same cycle. It expects the old contents from the read, then reads again in the following cycle to see the new value. Key handling and register access also overlap on the index port, because the byte that locks or advances the key is written through the same path as an index. The bench checks that 0xBB and the key bytes never replace the stored index: it reads that index back after re-opening the port. It also checks that soft reset clears the banks without closing the port.

// File: rtl/lockcfg_pkg.sv
package lockcfg_pkg;

   // key bytes and lock command seen on the index port
   localparam logic [7:0] KEY_FIRST  = 8'h51;
   localparam logic [7:0] KEY_SECOND = 8'h23;
   localparam logic [7:0] LOCK_CMD   = 8'hBB;

   // global register indices
   localparam logic [7:0] IX_SRST    = 8'h02;
   localparam logic [7:0] IX_DEVSEL  = 8'h07;
   localparam logic [7:0] IX_PD_DIR  = 8'h22;
   localparam logic [7:0] IX_PD_AUTO = 8'h23;
   localparam logic [7:0] IX_PINOPT  = 8'h24;

   // banked register indices
   localparam logic [7:0] IX_BANK_LO = 8'h30;
   localparam logic [7:0] IX_ACT     = 8'h30;
   localparam logic [7:0] IX_BASE_H  = 8'h60;
   localparam logic [7:0] IX_BASE_L  = 8'h61;
   localparam logic [7:0] IX_IRQ     = 8'h70;
   localparam logic [7:0] IX_IRQ2    = 8'h72;
   localparam logic [7:0] IX_DMA     = 8'h74;
   localparam logic [7:0] IX_MODE0   = 8'hF0;

   typedef enum logic {
      ST_LOCKED = 1'b0,
      ST_OPEN   = 1'b1
   } key_state_e;

endpackage

// File: rtl/lockcfg_key.sv
module lockcfg_key
   import lockcfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   output logic       is_open
);

   key_state_e st_q;
   logic       half_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_LOCKED;
         half_q <= 1'b0;
      end else if (idx_wr) begin
         case (st_q)
            ST_LOCKED: begin
               if (half_q && wdata == KEY_SECOND) begin
                  st_q   <= ST_OPEN;
                  half_q <= 1'b0;
               end else begin
                  half_q <= (wdata == KEY_FIRST);
               end
            end
            default: begin
               half_q <= 1'b0;
               if (wdata == LOCK_CMD) st_q <= ST_LOCKED;
            end
         endcase
      end
   end

   assign is_open = (st_q == ST_OPEN);

   // R2
   key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LOCKED && half_q && idx_wr && wdata == KEY_SECOND) |=> is_open);

   // R3
   key_noskip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LOCKED && !half_q && idx_wr && wdata != KEY_FIRST) |=> (!is_open && !half_q));

   // R5
   key_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_open && idx_wr && wdata == LOCK_CMD) |=> !is_open);

endmodule

// File: rtl/lockcfg_glob.sv
module lockcfg_glob
   import lockcfg_pkg::*;
#(
   parameter int DEVW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [7:0]      idx,
   input  logic [7:0]      wdata,
   output logic            srst,
   output logic [DEVW-1:0] devsel,
   output logic [7:0]      pd_dir,
   output logic [7:0]      pd_auto,
   output logic [7:0]      pinopt,
   output logic [7:0]      rd_val
);

   generate
      if (DEVW < 1 || DEVW > 8) begin : g_bad_devw
         $error("lockcfg_glob: DEVW must be 1..8");
      end
   endgenerate

   assign srst = wr_en && (idx == IX_SRST) && wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n || srst) begin
         devsel  <= '0;
         pd_dir  <= '0;
         pd_auto <= '0;
         pinopt  <= '0;
      end else if (wr_en) begin
         case (idx)
            IX_DEVSEL:  devsel  <= wdata[DEVW-1:0];
            IX_PD_DIR:  pd_dir  <= wdata;
            IX_PD_AUTO: pd_auto <= wdata;
            IX_PINOPT:  pinopt  <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (idx)
         IX_DEVSEL:  rd_val = {{(8-DEVW){1'b0}}, devsel};
         IX_PD_DIR:  rd_val = pd_dir;
         IX_PD_AUTO: rd_val = pd_auto;
         IX_PINOPT:  rd_val = pinopt;
         default:    rd_val = 8'h00;
      endcase
   end

   // R10
   glob_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (devsel == '0 && pd_dir == 8'h00 && pd_auto == 8'h00 && pinopt == 8'h00));

   // R9
   glob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(pd_dir) && $stable(pd_auto) && $stable(pinopt) && $stable(devsel)));

endmodule

// File: rtl/lockcfg_bank.sv
module lockcfg_bank
   import lockcfg_pkg::*;
#(
   parameter int NMODE    = 5,
   parameter int IRQW     = 8,
   parameter bit HAS_IRQ2 = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            wr_en,
   input  logic [7:0]      idx,
   input  logic [7:0]      wdata,
   output logic            act,
   output logic [15:0]     base,
   output logic [IRQW-1:0] irq,
   output logic [7:0]      rd_val
);

   localparam int ZPAD = 8 - IRQW;

   generate
      if (NMODE < 1 || NMODE > 15) begin : g_bad_nmode
         $error("lockcfg_bank: NMODE must be 1..15");
      end
      if (IRQW < 1 || IRQW > 8) begin : g_bad_irqw
         $error("lockcfg_bank: IRQW must be 1..8");
      end
   endgenerate

   logic [7:0] dma_q;
   logic [7:0] mode_q [NMODE];
   logic [7:0] irq2_v;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         act   <= 1'b0;
         base  <= '0;
         irq   <= '0;
         dma_q <= '0;
         for (int m = 0; m < NMODE; m++) mode_q[m] <= '0;
      end else if (wr_en) begin
         case (idx)
            IX_ACT:    act         <= wdata[0];
            IX_BASE_H: base[15:8]  <= wdata;
            IX_BASE_L: base[7:0]   <= wdata;
            IX_IRQ:    irq         <= wdata[IRQW-1:0];
            IX_DMA:    dma_q       <= wdata;
            default: ;
         endcase
         for (int m = 0; m < NMODE; m++) begin
            if (idx == IX_MODE0 + 8'(m)) mode_q[m] <= wdata;
         end
      end
   end

   generate
      if (HAS_IRQ2) begin : g_irq2
         logic [7:0] irq2_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr)                 irq2_q <= '0;
            else if (wr_en && idx == IX_IRQ2)  irq2_q <= wdata;
         end
         assign irq2_v = irq2_q;
      end else begin : g_no_irq2
         assign irq2_v = 8'h00;
      end
   endgenerate

   always_comb begin
      case (idx)
         IX_ACT:    rd_val = {7'b0, act};
         IX_BASE_H: rd_val = base[15:8];
         IX_BASE_L: rd_val = base[7:0];
         IX_IRQ:    rd_val = {{ZPAD{1'b0}}, irq};
         IX_IRQ2:   rd_val = irq2_v;
         IX_DMA:    rd_val = dma_q;
         default:   rd_val = 8'h00;
      endcase
      for (int m = 0; m < NMODE; m++) begin
         if (idx == IX_MODE0 + 8'(m)) rd_val = mode_q[m];
      end
   end

   // R10
   bank_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!act && base == 16'h0000 && irq == '0));

   // R6
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !clr) |=> ($stable(act) && $stable(base) && $stable(irq)));

endmodule

// File: rtl/lockcfg_port.sv
module lockcfg_port
   import lockcfg_pkg::*;
#(
   parameter int NDEV    = 9,
   parameter int KBD_DEV = 7,
   parameter int NMODE   = 5,
   parameter int IRQW    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 io_wr,
   input  logic                 io_rd,
   input  logic                 io_dsel,
   input  logic [7:0]           io_wdata,
   output logic [7:0]           io_rdata,
   output logic [NDEV-1:0]      dev_act,
   output logic [NDEV*16-1:0]   dev_base,
   output logic [NDEV*IRQW-1:0] dev_irq,
   output logic [7:0]           pd_direct,
   output logic [7:0]           pd_auto,
   output logic [7:0]           pin_opt
);

   localparam int DEVW = (NDEV > 1) ? $clog2(NDEV) : 1;

   generate
      if (NDEV < 1 || NDEV > 16) begin : g_bad_ndev
         $error("lockcfg_port: NDEV must be 1..16");
      end
      if (KBD_DEV < 0 || KBD_DEV >= NDEV) begin : g_bad_kbd
         $error("lockcfg_port: KBD_DEV must name an existing device");
      end
   endgenerate

   logic            is_open;
   logic [7:0]      idx_q;
   logic            idx_wr, dat_wr;
   logic            srst;
   logic [DEVW-1:0] devsel;
   logic [7:0]      glob_rd;
   logic [7:0]      bank_rd [NDEV];
   logic [7:0]      sel_rd;

   assign idx_wr = io_wr && !io_dsel;
   assign dat_wr = io_wr && io_dsel && is_open;

   lockcfg_key u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx_wr  (idx_wr),
      .wdata   (io_wdata),
      .is_open (is_open)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                                        idx_q <= '0;
      else if (idx_wr && is_open && io_wdata != LOCK_CMD) idx_q <= io_wdata;
   end

   lockcfg_glob #(.DEVW(DEVW)) u_glob (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (dat_wr && idx_q < IX_BANK_LO),
      .idx     (idx_q),
      .wdata   (io_wdata),
      .srst    (srst),
      .devsel  (devsel),
      .pd_dir  (pd_direct),
      .pd_auto (pd_auto),
      .pinopt  (pin_opt),
      .rd_val  (glob_rd)
   );

   generate
      for (genvar d = 0; d < NDEV; d++) begin : g_bank
         lockcfg_bank #(
            .NMODE    (NMODE),
            .IRQW     (IRQW),
            .HAS_IRQ2 (d == KBD_DEV)
         ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (srst),
            .wr_en  (dat_wr && idx_q >= IX_BANK_LO && devsel == DEVW'(d)),
            .idx    (idx_q),
            .wdata  (io_wdata),
            .act    (dev_act[d]),
            .base   (dev_base[d*16 +: 16]),
            .irq    (dev_irq[d*IRQW +: IRQW]),
            .rd_val (bank_rd[d])
         );
      end
   endgenerate

   always_comb begin
      sel_rd = 8'h00;
      for (int d = 0; d < NDEV; d++) begin
         if (devsel == DEVW'(d)) sel_rd = bank_rd[d];
      end
   end

   always_comb begin
      if (!io_rd)                  io_rdata = 8'h00;
      else if (!is_open)           io_rdata = 8'hFF;
      else if (!io_dsel)           io_rdata = idx_q;
      else if (idx_q < IX_BANK_LO) io_rdata = glob_rd;
      else                         io_rdata = sel_rd;
   end

   // R4
   lock_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !is_open) |-> io_rdata == 8'hFF);

   // R4
   lock_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_open |=> $stable(idx_q));

   // R10
   srst_stays_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> is_open);

endmodule

// File: tb/lockcfg_port_tb.sv
module lockcfg_port_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NDEV = 9;
   localparam int IRQW = 8;

   typedef struct packed {
      logic       rd;
      logic       dsel;
      logic [7:0] d;
      logic [7:0] exp;
      logic [3:0] req;
   } vec_t;

   // I = index port (dsel 0), D = data port (dsel 1); rd=0 means a write of d
   localparam int NV = 68;
   localparam vec_t VEC [NV] = '{
      '{1'b1,1'b1,8'h00,8'hFF,4'd4},  // R4 locked data read
      '{1'b1,1'b0,8'h00,8'hFF,4'd4},  // R4 locked index read
      '{1'b0,1'b0,8'h23,8'h00,4'd3},  // R3 lone second key byte
      '{1'b1,1'b1,8'h00,8'hFF,4'd3},
      '{1'b0,1'b0,8'h51,8'h00,4'd3},
      '{1'b0,1'b0,8'h00,8'h00,4'd3},  // R3 breaks the key
      '{1'b0,1'b0,8'h23,8'h00,4'd3},
      '{1'b1,1'b1,8'h00,8'hFF,4'd3},
      '{1'b0,1'b0,8'h51,8'h00,4'd2},  // R2 repeated first byte
      '{1'b0,1'b0,8'h51,8'h00,4'd2},
      '{1'b0,1'b0,8'h23,8'h00,4'd2},
      '{1'b0,1'b0,8'h07,8'h00,4'd6},
      '{1'b1,1'b0,8'h00,8'h07,4'd2},  // R2 index readback
      '{1'b0,1'b1,8'h03,8'h00,4'd6},
      '{1'b1,1'b1,8'h00,8'h03,4'd6},  // R6 device select
      '{1'b0,1'b0,8'h30,8'h00,4'd7},
      '{1'b0,1'b1,8'h01,8'h00,4'd7},
      '{1'b1,1'b1,8'h00,8'h01,4'd7},  // R7 enable
      '{1'b0,1'b0,8'h60,8'h00,4'd7},
      '{1'b0,1'b1,8'h12,8'h00,4'd7},
      '{1'b0,1'b0,8'h61,8'h00,4'd7},
      '{1'b0,1'b1,8'h34,8'h00,4'd7},
      '{1'b1,1'b1,8'h00,8'h34,4'd7},  // R7 base low
      '{1'b0,1'b0,8'h70,8'h00,4'd7},
      '{1'b0,1'b1,8'h05,8'h00,4'd7},
      '{1'b0,1'b0,8'h74,8'h00,4'd7},
      '{1'b0,1'b1,8'h02,8'h00,4'd7},
      '{1'b1,1'b1,8'h00,8'h02,4'd7},  // R7 dma
      '{1'b0,1'b0,8'hF4,8'h00,4'd7},
      '{1'b0,1'b1,8'hA5,8'h00,4'd7},
      '{1'b1,1'b1,8'h00,8'hA5,4'd7},  // R7 last mode register
      '{1'b0,1'b0,8'hF3,8'h00,4'd7},
      '{1'b1,1'b1,8'h00,8'h00,4'd7},  // R7 mode registers separate
      '{1'b0,1'b0,8'h72,8'h00,4'd8},
      '{1'b0,1'b1,8'h09,8'h00,4'd8},
      '{1'b1,1'b1,8'h00,8'h00,4'd8},  // R8 no second IRQ in bank 3
      '{1'b0,1'b0,8'h07,8'h00,4'd8},
      '{1'b0,1'b1,8'h07,8'h00,4'd8},
      '{1'b0,1'b0,8'h72,8'h00,4'd8},
      '{1'b0,1'b1,8'h0B,8'h00,4'd8},
      '{1'b1,1'b1,8'h00,8'h0B,4'd8},  // R8 keyboard second IRQ
      '{1'b0,1'b0,8'hF4,8'h00,4'd6},
      '{1'b1,1'b1,8'h00,8'h00,4'd6},  // R6 bank 7 mode untouched
      '{1'b0,1'b0,8'h07,8'h00,4'd6},
      '{1'b0,1'b1,8'h03,8'h00,4'd6},
      '{1'b0,1'b0,8'hF4,8'h00,4'd6},
      '{1'b1,1'b1,8'h00,8'hA5,4'd6},  // R6 bank 3 mode kept
      '{1'b0,1'b0,8'h22,8'h00,4'd9},
      '{1'b0,1'b1,8'h11,8'h00,4'd9},
      '{1'b1,1'b1,8'h00,8'h11,4'd9},  // R9
      '{1'b0,1'b0,8'h23,8'h00,4'd9},
      '{1'b0,1'b1,8'h22,8'h00,4'd9},
      '{1'b0,1'b0,8'h24,8'h00,4'd9},
      '{1'b0,1'b1,8'h44,8'h00,4'd9},
      '{1'b1,1'b1,8'h00,8'h44,4'd9},  // R9
      '{1'b0,1'b0,8'h40,8'h00,4'd11},
      '{1'b0,1'b1,8'h77,8'h00,4'd11},
      '{1'b1,1'b1,8'h00,8'h00,4'd11}, // R11 bank hole
      '{1'b0,1'b0,8'h25,8'h00,4'd11},
      '{1'b1,1'b1,8'h00,8'h00,4'd11}, // R11 global hole
      '{1'b0,1'b0,8'h24,8'h00,4'd5},
      '{1'b0,1'b0,8'hBB,8'h00,4'd5},
      '{1'b1,1'b1,8'h00,8'hFF,4'd5},  // R5 locked again
      '{1'b0,1'b1,8'h00,8'h00,4'd4},  // R4 ignored write
      '{1'b0,1'b0,8'h51,8'h00,4'd4},
      '{1'b0,1'b0,8'h23,8'h00,4'd4},
      '{1'b1,1'b0,8'h00,8'h24,4'd4},  // R4/R5 index kept
      '{1'b1,1'b1,8'h00,8'h44,4'd4}   // R4 register kept
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic io_wr = 1'b0, io_rd = 1'b0, io_dsel = 1'b0;
   logic [7:0] io_wdata = 8'h00;
   logic [7:0] io_rdata;
   logic [NDEV-1:0]      dev_act;
   logic [NDEV*16-1:0]   dev_base;
   logic [NDEV*IRQW-1:0] dev_irq;
   logic [7:0] pd_direct, pd_auto, pin_opt;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lockcfg_port u_dut (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_dsel(io_dsel),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_act(dev_act),
      .dev_base(dev_base), .dev_irq(dev_irq), .pd_direct(pd_direct),
      .pd_auto(pd_auto), .pin_opt(pin_opt)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one bus cycle; read data sampled before the committing edge
   task automatic cyc(input logic wr, input logic rd, input logic dsel,
                      input logic [7:0] d, output logic [7:0] got);
      @(negedge clk);
      io_wr = wr; io_rd = rd; io_dsel = dsel; io_wdata = d;
      #1 got = io_rdata;
      @(posedge clk);
      #1 io_wr = 1'b0; io_rd = 1'b0;
   endtask

   task automatic wr_i(input logic [7:0] d);
      logic [7:0] g;
      cyc(1'b1, 1'b0, 1'b0, d, g);
   endtask

   task automatic wr_d(input logic [7:0] d);
      logic [7:0] g;
      cyc(1'b1, 1'b0, 1'b1, d, g);
   endtask

   task automatic rd_port(input logic dsel, output logic [7:0] got);
      cyc(1'b0, 1'b1, dsel, 8'h00, got);
   endtask

   initial begin
      logic [7:0] got;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 dev_act", 32'(dev_act), 32'h0);
      check("R1 dev_base3", 32'(dev_base[3*16 +: 16]), 32'h0);
      check("R1 pd_direct", 32'(pd_direct), 32'h0);
      rd_port(1'b1, got);
      check("R1 locked", 32'(got), 32'hFF);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].rd) begin
            rd_port(VEC[i].dsel, got);
            n_chk++;
            if (got !== VEC[i].exp) begin
               n_fail++;
               $display("FAIL R%0d vector %0d actual=%0h expected=%0h",
                        VEC[i].req, i, got, VEC[i].exp);
            end
         end else begin
            if (VEC[i].dsel) wr_d(VEC[i].d);
            else             wr_i(VEC[i].d);
         end
      end

      // R7 exported device fields
      @(negedge clk);
      check("R7 dev_act", 32'(dev_act), 32'h008);
      check("R7 dev_base3", 32'(dev_base[3*16 +: 16]), 32'h1234);
      check("R7 dev_irq3", 32'(dev_irq[3*IRQW +: IRQW]), 32'h05);
      check("R9 pd_auto", 32'(pd_auto), 32'h22);
      check("R9 pin_opt", 32'(pin_opt), 32'h44);

      // R10 soft reset
      wr_i(8'h02);
      wr_d(8'h00);
      @(negedge clk);
      check("R10 bit0 clear no effect", 32'(pd_direct), 32'h11);
      wr_d(8'h01);
      @(negedge clk);
      check("R10 pd_direct cleared", 32'(pd_direct), 32'h00);
      check("R10 dev_act cleared", 32'(dev_act), 32'h0);
      check("R10 dev_base cleared", 32'(dev_base[3*16 +: 16]), 32'h0);
      rd_port(1'b0, got);
      check("R10 still open", 32'(got), 32'h02);
      wr_i(8'h07);
      rd_port(1'b1, got);
      check("R10 devsel cleared", 32'(got), 32'h00);

      // R12 read and write in the same cycle
      wr_i(8'h22);
      cyc(1'b1, 1'b1, 1'b1, 8'h5A, got);
      check("R12 old value", 32'(got), 32'h00);
      rd_port(1'b1, got);
      check("R12 new value", 32'(got), 32'h5A);

      // R13 device number out of range
      wr_i(8'h07);
      wr_d(8'h0C);
      rd_port(1'b1, got);
      check("R13 devsel stored", 32'(got), 32'h0C);
      wr_i(8'h30);
      wr_d(8'h01);
      rd_port(1'b1, got);
      check("R13 bank read zero", 32'(got), 32'h00);
      check("R13 no enable", 32'(dev_act), 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule